// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Cache

This block is a small set-associative tag array with one data word per line. Each line also carries a reservation owner field. A single request stream accepts four kinds of operation: plain loads, plain stores, load-linked and store-conditional. Each request carries a hardware context number and a byte address. A load-linked that hits records the requesting context as the line's owner. A later store-conditional writes only if that same context still owns the line. The response reports the outcome as a success bit.

A separate coherence input removes lines or changes their permission. Removing a line, replacing it and downgrading its permission all drop the reservation. An upgrade to read-write keeps the reservation. The reservation test and the write are made in one cycle, and coherence events never interleave with a request. This gives software an atomic read-modify-write primitive per context without a global link register.

Request and response are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and is held unchanged until `rsp_ready` is seen high. While a response is held, `req_ready` stays low, so back-pressure on the response stalls the request side. The coherence input is plain control: it has no ready signal and is always applied in the cycle it is asserted.

Top module: `llsc_resv_cache`

## Requirements
- R1: After reset no line is valid, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Operation codes are 2'b00 load, 2'b01 store, 2'b10 load-linked and 2'b11 store-conditional. A load or store that hits reads or writes the line word and reports `rsp_hit`=1. A load or store that misses allocates the line and reports `rsp_hit`=0. A store miss fills the line with the write data, and a load miss fills it with zero and returns zero.
- R3: The address is {tag[3:0], set[1:0], offset[1:0]}. The two offset bits play no part in line matching, data selection or reservation tests.
- R4: A load-linked that hits returns the line word and makes the requesting context the line's owner. A load-linked that misses reports `rsp_hit`=0 and allocates nothing.
- R5: A store-conditional whose context owns the line writes the data, reports `rsp_sc_ok`=1 and clears the owner, so a repeat store-conditional fails. `rsp_sc_ok` is 0 for every other operation.
- R6: A store-conditional that hits a line owned by another context, or by no context, is still answered with `rsp_hit`=1 and `rsp_sc_ok`=0, and leaves the line word unchanged.
- R7: A store-conditional that misses reports `rsp_hit`=0 and `rsp_sc_ok`=0 and allocates nothing.
- R8: A load-linked by a second context takes the reservation from the first context.
- R9: An allocation fills the lowest invalid way. If no way is invalid, it replaces the way named by a per-set round-robin pointer, which starts at 0 and advances on each replacement. An allocated line starts with no owner. A replaced line is gone.
- R10: A coherence event with code 2'b00 removes a matching line, dropping its data and its reservation.
- R11: A coherence code of 2'b01 (read-only) or 2'b11 (no access) keeps the line but clears its owner. Code 2'b10 (read-write) keeps the owner. An event whose line address matches no valid line changes nothing.
- R12: While `coh_valid` is high, `req_ready` is low and no request is taken.
- R13: A response appears in the cycle after its request is taken. While `rsp_ready` is low it holds its fields, and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | Operation code |
| req_ctx | input | 2 | Requesting context number |
| req_addr | input | 8 | Byte address {tag, set, offset} |
| req_wdata | input | 16 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Line was present |
| rsp_sc_ok | output | 1 | Store-conditional succeeded |
| rsp_rdata | output | 16 | Load data (zero for stores) |
| coh_valid | input | 1 | Coherence event present |
| coh_op | input | 2 | 00 remove, 01 read-only, 10 read-write, 11 no access |
| coh_line | input | 6 | Line address {tag, set} of the event |

## Verification
The bench sweeps every pairing of the context that issues a load-linked with the context that issues a store-conditional, and it varies the offset bits on each access. A design that compared the wrong field, or matched on the offset, would report success for the wrong pairs or lose the line's word. It fills a set beyond its ways to check replacement order, and that a refilled line does not keep its old owner. A design that forgot to clear the owner on allocation would let a stale store-conditional succeed. Each coherence code is applied to an owned line, to catch a read-write upgrade that drops the reservation or a downgrade that keeps it. Response back-pressure, and a coherence event that collides with a request, check that the response is held unchanged and that no request slips in while either is active.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'b00,
    OP_ST = 2'b01,
    OP_LL = 2'b10,
    OP_SC = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    COH_REMOVE = 2'b00,
    COH_RO     = 2'b01,
    COH_RW     = 2'b10,
    COH_NOACC  = 2'b11
  } coh_e;
endpackage

// File: rtl/llsc_tag_lookup.sv
module llsc_tag_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_i[w] && tags_i[w] == tag_i) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/llsc_victim_sel.sv
module llsc_victim_sel #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);
  always_comb begin
    full_o = &valid_i;
    way_o  = rr_i;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/llsc_resv_cache.sv
module llsc_resv_cache
  import llsc_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int TAG_W   = 4,
  parameter int OFF_W   = 2,
  parameter int DATA_W  = 16,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = TAG_W + SET_W,
  localparam int ADDR_W = LINE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_sc_ok,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              coh_valid,
  input  logic [1:0]        coh_op,
  input  logic [LINE_W-1:0] coh_line
);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int RESV_W = CTX_W + 1;
  localparam logic [RESV_W-1:0] RESV_NONE = '1;

  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [DATA_W-1:0]          data_q  [SETS][WAYS];
  logic [RESV_W-1:0]          resv_q  [SETS][WAYS];
  logic [WAY_W-1:0]           rr_q    [SETS];

  logic [SET_W-1:0] req_set, coh_set;
  logic [TAG_W-1:0] req_tag, coh_tag;
  logic [OFF_W-1:0] req_off_unused;
  logic             req_hit, coh_hit, set_full, req_fire, resv_match, do_alloc;
  logic [WAY_W-1:0] req_way, coh_way, vic_way, rr_next;
  op_e              op;

  assign req_off_unused = req_addr[OFF_W-1:0];
  assign req_set = req_addr[OFF_W +: SET_W];
  assign req_tag = req_addr[OFF_W+SET_W +: TAG_W];
  assign coh_set = coh_line[SET_W-1:0];
  assign coh_tag = coh_line[SET_W +: TAG_W];
  assign op      = op_e'(req_op);

  llsc_tag_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_lookup (
    .valid_i(valid_q[req_set]), .tags_i(tag_q[req_set]), .tag_i(req_tag),
    .hit_o(req_hit), .way_o(req_way)
  );

  llsc_tag_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_coh_lookup (
    .valid_i(valid_q[coh_set]), .tags_i(tag_q[coh_set]), .tag_i(coh_tag),
    .hit_o(coh_hit), .way_o(coh_way)
  );

  llsc_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid_i(valid_q[req_set]), .rr_i(rr_q[req_set]),
    .way_o(vic_way), .full_o(set_full)
  );

  assign req_ready  = (!rsp_valid || rsp_ready) && !coh_valid;
  assign req_fire   = req_valid && req_ready;
  assign resv_match = req_hit && (resv_q[req_set][req_way] == {1'b0, req_ctx});
  assign do_alloc   = req_fire && !req_hit && (op == OP_LD || op == OP_ST);
  assign rr_next    = (rr_q[req_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[req_set] + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tag_q[s]   <= '0;
        rr_q[s]    <= '0;
        for (int w = 0; w < WAYS; w++) begin
          data_q[s][w] <= '0;
          resv_q[s][w] <= RESV_NONE;
        end
      end
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_sc_ok <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;

      if (coh_valid && coh_hit) begin
        if (coh_e'(coh_op) == COH_REMOVE) begin
          valid_q[coh_set][coh_way] <= 1'b0;
          resv_q[coh_set][coh_way]  <= RESV_NONE;
        end else if (coh_e'(coh_op) != COH_RW) begin
          resv_q[coh_set][coh_way]  <= RESV_NONE;
        end
      end

      if (req_fire) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= req_hit;
        rsp_sc_ok <= 1'b0;
        rsp_rdata <= '0;
        unique case (op)
          OP_LD: if (req_hit) rsp_rdata <= data_q[req_set][req_way];
          OP_ST: if (req_hit) data_q[req_set][req_way] <= req_wdata;
          OP_LL: if (req_hit) begin
            rsp_rdata <= data_q[req_set][req_way];
            resv_q[req_set][req_way] <= {1'b0, req_ctx};
          end
          OP_SC: if (resv_match) begin
            data_q[req_set][req_way] <= req_wdata;
            resv_q[req_set][req_way] <= RESV_NONE;
            rsp_sc_ok <= 1'b1;
          end
          default: ;
        endcase
      end

      if (do_alloc) begin
        valid_q[req_set][vic_way] <= 1'b1;
        tag_q[req_set][vic_way]   <= req_tag;
        data_q[req_set][vic_way]  <= (op == OP_ST) ? req_wdata : '0;
        resv_q[req_set][vic_way]  <= RESV_NONE;
        if (set_full) rr_q[req_set] <= rr_next;
      end
    end
  end
endmodule

// File: rtl/llsc_resv_cache_chk.sv
module llsc_resv_cache_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              coh_valid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_sc_ok,
  input logic [DATA_W-1:0] rsp_rdata
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_sc_ok) && $stable(rsp_rdata)); // R13

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R13

  AST_HELD_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R13

  AST_COH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    coh_valid |-> !req_ready); // R12

  AST_SC_OK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_sc_ok |-> rsp_hit); // R7

  AST_SC_OK_ONLY_SC: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op != 2'b11 |=> !rsp_sc_ok); // R5
endmodule

bind llsc_resv_cache llsc_resv_cache_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .coh_valid(coh_valid), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_sc_ok(rsp_sc_ok),
  .rsp_rdata(rsp_rdata)
);

// File: tb/llsc_resv_cache_tb.sv
`timescale 1ns/1ps
module llsc_resv_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [1:0]  req_ctx = 2'b00;
  logic [7:0]  req_addr = 8'h00;
  logic [15:0] req_wdata = 16'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_sc_ok;
  logic [15:0] rsp_rdata;
  logic        coh_valid = 1'b0;
  logic [1:0]  coh_op = 2'b00;
  logic [5:0]  coh_line = 6'h0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic        r_hit, r_ok;
  logic [15:0] r_data;

  always #2.5 clk = ~clk;

  llsc_resv_cache u_dut (.*);

  task automatic chk(input bit cond, input string rq, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input int tag, input int set, input int off);
    return {tag[3:0], set[1:0], off[1:0]};
  endfunction

  task automatic do_req(input logic [1:0] op, input int ctx, input logic [7:0] addr,
                        input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ctx = ctx[1:0]; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R13 latency", int'(rsp_valid), 1);
    r_hit = rsp_hit; r_ok = rsp_sc_ok; r_data = rsp_rdata;
  endtask

  task automatic do_coh(input logic [1:0] op, input logic [5:0] line);
    @(negedge clk);
    coh_valid = 1'b1; coh_op = op; coh_line = line;
    @(negedge clk);
    coh_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    do_req(2'b00, 0, mk(0, 3, 0), 0);
    chk(r_hit == 1'b0, "R1 empty after reset", int'(r_hit), 0);

    // R2 load/store allocate and hit
    do_req(2'b00, 0, mk(1, 0, 0), 0);
    chk(r_hit == 0 && r_data == 0, "R2 load miss", int'(r_data), 0);
    do_req(2'b00, 0, mk(1, 0, 0), 0);
    chk(r_hit == 1 && r_data == 0, "R2 load hit", int'(r_hit), 1);
    do_req(2'b01, 0, mk(2, 2, 0), 16'h1234);
    chk(r_hit == 0 && r_ok == 0, "R2 store miss", int'(r_hit), 0);
    do_req(2'b00, 0, mk(2, 2, 0), 0);
    chk(r_hit == 1 && r_data == 16'h1234, "R2 store fill", int'(r_data), 16'h1234);
    do_req(2'b01, 0, mk(2, 2, 0), 16'h5678);
    chk(r_hit == 1 && r_ok == 0, "R5 store no sc_ok", int'(r_ok), 0);

    // R3 offsets ignored
    for (int o = 0; o < 4; o++) begin
      do_req(2'b00, 0, mk(2, 2, o), 0);
      chk(r_hit == 1 && r_data == 16'h5678, "R3 offset", int'(r_data), 16'h5678);
    end

    // R4 R5 R6 sweep of context pairs on line {3,3}
    do_req(2'b01, 0, mk(3, 3, 0), 16'h0);
    exp_c = 16'h0;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic [15:0] wd;
        wd = 16'(16'h100 * a + b + 1);
        do_req(2'b10, a, mk(3, 3, a), 0);
        chk(r_hit == 1 && r_data == exp_c, "R4 ll data", int'(r_data), int'(exp_c));
        do_req(2'b11, b, mk(3, 3, b), wd);
        chk(r_hit == 1 && r_ok == (a == b), "R6 sc ctx match", int'(r_ok), int'(a == b));
        if (a == b) exp_c = wd;
        do_req(2'b00, 0, mk(3, 3, 3 - a), 0);
        chk(r_data == exp_c, "R6 word after sc", int'(r_data), int'(exp_c));
      end
    end
    // R5 success clears owner
    do_req(2'b10, 1, mk(3, 3, 0), 0);
    do_req(2'b11, 1, mk(3, 3, 0), 16'hAAAA);
    chk(r_ok == 1, "R5 first sc", int'(r_ok), 1);
    do_req(2'b11, 1, mk(3, 3, 0), 16'hBBBB);
    chk(r_ok == 0 && r_hit == 1, "R5 repeat sc", int'(r_ok), 0);
    do_req(2'b00, 0, mk(3, 3, 0), 0);
    chk(r_data == 16'hAAAA, "R5 repeat no write", int'(r_data), 16'hAAAA);
    // R8 takeover
    do_req(2'b10, 0, mk(3, 3, 0), 0);
    do_req(2'b10, 2, mk(3, 3, 0), 0);
    do_req(2'b11, 0, mk(3, 3, 0), 16'h1111);
    chk(r_ok == 0, "R8 old owner fails", int'(r_ok), 0);
    do_req(2'b11, 2, mk(3, 3, 0), 16'h2222);
    chk(r_ok == 1, "R8 new owner ok", int'(r_ok), 1);

    // R7 sc miss, R4 ll miss
    do_req(2'b11, 0, mk(9, 0, 0), 16'h7);
    chk(r_hit == 0 && r_ok == 0, "R7 sc miss", int'(r_ok), 0);
    do_req(2'b00, 0, mk(9, 0, 0), 0);
    chk(r_hit == 0, "R7 sc no alloc", int'(r_hit), 0);
    do_req(2'b10, 0, mk(10, 0, 0), 0);
    chk(r_hit == 0, "R4 ll miss", int'(r_hit), 0);
    do_req(2'b11, 0, mk(10, 0, 0), 16'h9);
    chk(r_hit == 0 && r_ok == 0, "R4 ll no alloc", int'(r_hit), 0);

    // R9 replacement in set 1
    do_req(2'b00, 0, mk(1, 1, 0), 0);
    do_req(2'b01, 0, mk(2, 1, 0), 16'h22);
    do_req(2'b10, 0, mk(1, 1, 0), 0);
    chk(r_hit == 1, "R9 ll before evict", int'(r_hit), 1);
    do_req(2'b00, 0, mk(3, 1, 0), 0);
    chk(r_hit == 0, "R9 third tag misses", int'(r_hit), 0);
    do_req(2'b11, 0, mk(1, 1, 0), 16'h5);
    chk(r_hit == 0 && r_ok == 0, "R9 way0 evicted", int'(r_hit), 0);
    do_req(2'b00, 0, mk(2, 1, 0), 0);
    chk(r_hit == 1 && r_data == 16'h22, "R9 way1 kept", int'(r_data), 16'h22);
    do_req(2'b01, 0, mk(1, 1, 0), 16'h33);
    chk(r_hit == 0, "R9 refill miss", int'(r_hit), 0);
    do_req(2'b11, 0, mk(1, 1, 0), 16'h44);
    chk(r_hit == 1 && r_ok == 0, "R9 refill no owner", int'(r_ok), 0);
    do_req(2'b00, 0, mk(3, 1, 0), 0);
    chk(r_hit == 1, "R9 rr pointer advanced", int'(r_hit), 1);
    do_req(2'b00, 0, mk(2, 1, 0), 0);
    chk(r_hit == 0, "R9 second replace", int'(r_hit), 0);

    // R10 coherence remove
    do_req(2'b10, 2, mk(3, 3, 0), 0);
    do_coh(2'b00, {4'd3, 2'd3});
    do_req(2'b11, 2, mk(3, 3, 0), 16'h1);
    chk(r_hit == 0 && r_ok == 0, "R10 removed", int'(r_hit), 0);

    // R11 permission changes on line {5,2}
    do_req(2'b01, 0, mk(5, 2, 1), 16'h50);
    do_req(2'b10, 1, mk(5, 2, 2), 0);
    do_coh(2'b10, {4'd5, 2'd2});
    do_req(2'b11, 1, mk(5, 2, 0), 16'h51);
    chk(r_ok == 1, "R11 rw keeps", int'(r_ok), 1);
    do_req(2'b10, 1, mk(5, 2, 0), 0);
    do_coh(2'b01, {4'd5, 2'd2});
    do_req(2'b11, 1, mk(5, 2, 0), 16'h52);
    chk(r_hit == 1 && r_ok == 0, "R11 ro clears", int'(r_ok), 0);
    do_req(2'b10, 3, mk(5, 2, 0), 0);
    do_coh(2'b11, {4'd5, 2'd2});
    do_req(2'b11, 3, mk(5, 2, 0), 16'h53);
    chk(r_hit == 1 && r_ok == 0, "R11 noacc clears", int'(r_ok), 0);
    do_req(2'b10, 0, mk(5, 2, 0), 0);
    do_coh(2'b00, {4'd7, 2'd2});
    do_coh(2'b01, {4'd7, 2'd2});
    do_req(2'b11, 0, mk(5, 2, 0), 16'h54);
    chk(r_ok == 1, "R11 other line untouched", int'(r_ok), 1);

    // R12 coherence blocks request
    @(negedge clk);
    coh_valid = 1'b1; coh_op = 2'b10; coh_line = {4'd15, 2'd0};
    req_valid = 1'b1; req_op = 2'b00; req_addr = mk(2, 2, 0);
    #0.1;
    chk(req_ready == 1'b0, "R12 ready low", int'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 not taken", int'(rsp_valid), 0);
    coh_valid = 1'b0; req_valid = 1'b0;

    // R13 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'b00; req_addr = mk(2, 2, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1 && rsp_rdata == 16'h5678, "R13 response", int'(rsp_rdata), 16'h5678);
    chk(req_ready == 1'b0, "R13 ready held low", int'(req_ready), 0);
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == 16'h5678 && rsp_hit == 1, "R13 held", int'(rsp_rdata), 16'h5678);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R13 drained", int'(rsp_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule